// File: doc/BRIEF.md
# Logic Cell Output Stage with Edge Interrupt

This block sits at the end of a configurable logic cell. It takes the single-bit result of the cell's logic function and gives it an optional inversion. It publishes the corrected value as a status bit and can drive it onto a device pin. It also watches the corrected value for edges so it can raise an interrupt. While the cell enable is low, every output of the stage is held at 0, whatever the function result or the polarity setting.

Edges are measured after the inversion. Changing the polarity setting alone can therefore produce an edge. Edge detection runs only while the cell is enabled. The comparison copy of the output is held at 0 while the cell is off, so switching the cell on can itself raise the flag:

- If the output is high at switch-on, it counts as a rising edge.
- If the output is low at switch-on, it counts as a falling edge.

The flag is sticky. It sets whether or not the interrupt is unmasked, and it stays set until software pulses the clear strobe. The interrupt request is the flag gated by the mask bit.

Top module: `lcell_out_unit`

## Requirements
- R1: While `cell_en_i` is 1, `status_o` equals `func_raw_i` XOR `out_inv_i`. Inversion is selected by `out_inv_i`=1.
- R2: While `cell_en_i` is 0, `status_o`, `pin_o` and `pin_drv_o` are all 0, for any value of `func_raw_i` or `out_inv_i`.
- R3: `pin_drv_o` is 1 only when `cell_en_i` and `pin_oe_i` are both 1. When the pin is driven, `pin_o` equals `status_o`; otherwise `pin_o` is 0.
- R4: A 0-to-1 change of the corrected output while enabled and with `rise_en_i`=1 sets `flag_o` at the next clock edge. This includes a change caused only by toggling `out_inv_i`.
- R5: A 1-to-0 change of the corrected output while enabled and with `fall_en_i`=1 sets `flag_o` at the next clock edge.
- R6: Output edges do not set the flag in either of two cases: the matching edge enable is 0, or the cell is disabled.
- R7: Switching the cell on sets the flag in two cases: the corrected output is 1 and `rise_en_i`=1, or the corrected output is 0 and `fall_en_i`=1.
- R8: `flag_o` sets even when `irq_en_i` is 0. `irq_o` is 1 exactly when `flag_o` and `irq_en_i` are both 1.
- R9: A `flag_clr_i` pulse clears `flag_o` at the next clock edge. If a qualifying edge occurs in the same cycle, the flag stays set.
- R10: After reset `flag_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_raw_i | input | 1 | Raw logic function result |
| cell_en_i | input | 1 | Cell enable |
| pin_oe_i | input | 1 | Pin output enable |
| out_inv_i | input | 1 | Output polarity inversion |
| rise_en_i | input | 1 | Flag on rising output edge |
| fall_en_i | input | 1 | Flag on falling output edge |
| irq_en_i | input | 1 | Interrupt request mask (1 = pass) |
| flag_clr_i | input | 1 | Flag clear strobe |
| pin_o | output | 1 | Pin data |
| pin_drv_o | output | 1 | Pin drive enable |
| status_o | output | 1 | Polarity-corrected output status |
| flag_o | output | 1 | Sticky edge flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The polarity path is driven with all four combinations of raw value and inversion. The same combinations are repeated with the cell off, which separates a missing enable gate from a missing inverter. The edge detector is exercised in several ways:

- Raw-input edges and polarity-only edges, which show whether detection sits after the inverter.
- Edges with each edge enable off and with the cell off.
- Switch-on with the output both high and low, which exposes a comparison copy that is not cleared while the cell is off.

The clear strobe is applied alone and together with a fresh edge, which shows whether set or clear has priority.

// File: rtl/lcell_out_pkg.sv
package lcell_out_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
    logic wake;
  } lcell_evt_t;

  localparam int unsigned RST_SYNC_STAGES = 2;
endpackage

// File: rtl/lcell_rst_sync.sv
module lcell_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned LAST = STAGES - 1;
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/lcell_polarity.sv
module lcell_polarity (
  input  logic cell_en,
  input  logic func_raw,
  input  logic out_inv,
  input  logic pin_oe,
  output logic cell_out,
  output logic pin_data,
  output logic pin_drv
);
  logic corrected;

  always_comb begin
    corrected = func_raw ^ out_inv;
    cell_out  = cell_en & corrected;
    pin_drv   = cell_en & pin_oe;
    pin_data  = pin_drv & cell_out;
  end
endmodule

// File: rtl/lcell_edge_det.sv
module lcell_edge_det
  import lcell_out_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cell_en,
  input  logic       cell_out,
  input  logic       rise_en,
  input  logic       fall_en,
  output lcell_evt_t evt,
  output logic       hit
);
  logic prev_q, prev_d;
  logic en_q, en_d;

  // Comparison copy is held low while the cell is off.
  always_comb begin
    prev_d   = cell_en ? cell_out : 1'b0;
    en_d     = cell_en;
    evt.wake = cell_en & ~en_q;
    evt.rise = cell_en & cell_out & ~prev_q;
    evt.fall = cell_en & ~cell_out & (prev_q | evt.wake);
    hit      = (evt.rise & rise_en) | (evt.fall & fall_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      prev_q <= prev_d;
      en_q   <= en_d;
    end
  end
endmodule

// File: rtl/lcell_flag.sv
module lcell_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_d, flag_ce;

  // A new edge wins over a clear in the same cycle.
  always_comb begin
    flag_ce = hit | clr;
    flag_d  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign irq  = flag_q & irq_en;
endmodule

// File: rtl/lcell_out_unit.sv
module lcell_out_unit
  import lcell_out_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic func_raw_i,
  input  logic cell_en_i,
  input  logic pin_oe_i,
  input  logic out_inv_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  input  logic irq_en_i,
  input  logic flag_clr_i,
  output logic pin_o,
  output logic pin_drv_o,
  output logic status_o,
  output logic flag_o,
  output logic irq_o
);
  logic       rst_int_n;
  logic       cell_out;
  logic       hit;
  lcell_evt_t evt;

  lcell_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  lcell_polarity u_pol (
    .cell_en(cell_en_i), .func_raw(func_raw_i), .out_inv(out_inv_i),
    .pin_oe(pin_oe_i), .cell_out(cell_out), .pin_data(pin_o),
    .pin_drv(pin_drv_o)
  );

  lcell_edge_det u_edge (
    .clk(clk), .rst_n(rst_int_n), .cell_en(cell_en_i), .cell_out(cell_out),
    .rise_en(rise_en_i), .fall_en(fall_en_i), .evt(evt), .hit(hit)
  );

  lcell_flag u_flag (
    .clk(clk), .rst_n(rst_int_n), .hit(hit), .clr(flag_clr_i),
    .irq_en(irq_en_i), .flag(flag_o), .irq(irq_o)
  );

  assign status_o = cell_out;
endmodule

// File: rtl/lcell_out_chk.sv
module lcell_out_chk (
  input logic clk,
  input logic rst_n,
  input logic cell_en_i,
  input logic pin_oe_i,
  input logic rise_en_i,
  input logic fall_en_i,
  input logic irq_en_i,
  input logic flag_clr_i,
  input logic pin_o,
  input logic pin_drv_o,
  input logic status_o,
  input logic flag_o,
  input logic irq_o
);
  logic st_q, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= 1'b0;
      en_q <= 1'b0;
    end else begin
      st_q <= status_o;
      en_q <= cell_en_i;
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_en_i |-> (!status_o && !pin_o && !pin_drv_o)); // R2
  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(cell_en_i && pin_oe_i) |-> !pin_drv_o); // R3
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en_i && en_q && rise_en_i && status_o && !st_q) |=> flag_o); // R4
  AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en_i && en_q && fall_en_i && !status_o && st_q) |=> flag_o); // R5
  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(cell_en_i)); // R6
  AST_WAKE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en_i && !en_q && fall_en_i && !status_o) |=> flag_o); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_o && irq_en_i)); // R8
  AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(flag_clr_i)); // R9
endmodule

bind lcell_out_unit lcell_out_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cell_en_i(cell_en_i), .pin_oe_i(pin_oe_i),
  .rise_en_i(rise_en_i), .fall_en_i(fall_en_i), .irq_en_i(irq_en_i),
  .flag_clr_i(flag_clr_i), .pin_o(pin_o), .pin_drv_o(pin_drv_o),
  .status_o(status_o), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/sim_lcell_out_unit.sv
module sim_lcell_out_unit;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic func_raw_i, cell_en_i, pin_oe_i, out_inv_i;
  logic rise_en_i, fall_en_i, irq_en_i, flag_clr_i;
  logic pin_o, pin_drv_o, status_o, flag_o, irq_o;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcell_out_unit u0 (
    .clk(clk), .rst_n(rst_n), .func_raw_i(func_raw_i), .cell_en_i(cell_en_i),
    .pin_oe_i(pin_oe_i), .out_inv_i(out_inv_i), .rise_en_i(rise_en_i),
    .fall_en_i(fall_en_i), .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
    .pin_o(pin_o), .pin_drv_o(pin_drv_o), .status_o(status_o),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic check(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_idle();
    cell_en_i = 0; rise_en_i = 0; fall_en_i = 0; irq_en_i = 0;
    func_raw_i = 0; out_inv_i = 0; pin_oe_i = 0;
    flag_clr_i = 1; step();
    flag_clr_i = 0; step();
  endtask

  task automatic t_reset();
    check("R10 flag after reset", flag_o, 1'b0);
    check("R10 irq after reset", irq_o, 1'b0);
  endtask

  task automatic t_polarity();
    go_idle();
    cell_en_i = 1;
    for (int k = 0; k < 4; k++) begin
      func_raw_i = k[0]; out_inv_i = k[1]; #1;
      check("R1 status", status_o, k[0] ^ k[1]);
    end
  endtask

  task automatic t_disabled();
    go_idle();
    pin_oe_i = 1;
    for (int k = 0; k < 4; k++) begin
      func_raw_i = k[0]; out_inv_i = k[1]; #1;
      check("R2 status off", status_o, 1'b0);
      check("R2 pin off", pin_o, 1'b0);
      check("R2 drv off", pin_drv_o, 1'b0);
    end
  endtask

  task automatic t_pin();
    go_idle();
    cell_en_i = 1; func_raw_i = 1; pin_oe_i = 0; #1;
    check("R3 drv oe=0", pin_drv_o, 1'b0);
    check("R3 pin oe=0", pin_o, 1'b0);
    pin_oe_i = 1; #1;
    check("R3 drv on", pin_drv_o, 1'b1);
    check("R3 pin follows", pin_o, 1'b1);
    out_inv_i = 1; #1;
    check("R3 pin inverted", pin_o, 1'b0);
  endtask

  task automatic t_rise();
    go_idle();
    cell_en_i = 1; rise_en_i = 1; step();
    check("R4 no edge yet", flag_o, 1'b0);
    func_raw_i = 1; step();
    check("R4 raw rise", flag_o, 1'b1);
    flag_clr_i = 1; step(); flag_clr_i = 0;
    func_raw_i = 0; step();
    out_inv_i = 1; step();
    check("R4 polarity rise", flag_o, 1'b1);
  endtask

  task automatic t_fall();
    go_idle();
    cell_en_i = 1; func_raw_i = 1; fall_en_i = 1; step();
    check("R5 no edge yet", flag_o, 1'b0);
    func_raw_i = 0; step();
    check("R5 raw fall", flag_o, 1'b1);
  endtask

  task automatic t_ignored();
    go_idle();
    cell_en_i = 1; step();
    for (int k = 0; k < 4; k++) begin
      func_raw_i = ~func_raw_i; step();
    end
    check("R6 edge enables off", flag_o, 1'b0);
    cell_en_i = 0; rise_en_i = 1; fall_en_i = 1; step();
    for (int k = 0; k < 4; k++) begin
      func_raw_i = ~func_raw_i; step();
    end
    check("R6 cell off", flag_o, 1'b0);
  endtask

  task automatic t_wake();
    go_idle();
    func_raw_i = 1; rise_en_i = 1; cell_en_i = 1; step();
    check("R7 wake high", flag_o, 1'b1);
    go_idle();
    func_raw_i = 0; fall_en_i = 1; cell_en_i = 1; step();
    check("R7 wake low", flag_o, 1'b1);
    go_idle();
    func_raw_i = 0; rise_en_i = 1; cell_en_i = 1; step();
    check("R7 wake low rise only", flag_o, 1'b0);
  endtask

  task automatic t_irq();
    go_idle();
    cell_en_i = 1; rise_en_i = 1; step();
    func_raw_i = 1; step();
    check("R8 flag while masked", flag_o, 1'b1);
    check("R8 irq masked", irq_o, 1'b0);
    irq_en_i = 1; #1;
    check("R8 irq unmasked", irq_o, 1'b1);
  endtask

  task automatic t_clear();
    go_idle();
    cell_en_i = 1; rise_en_i = 1; step();
    func_raw_i = 1; step();
    func_raw_i = 0; step();
    func_raw_i = 1; flag_clr_i = 1; step();
    flag_clr_i = 0;
    check("R9 set beats clear", flag_o, 1'b1);
    flag_clr_i = 1; step(); flag_clr_i = 0;
    check("R9 clear", flag_o, 1'b0);
  endtask

  initial begin
    rst_n = 0;
    cell_en_i = 0; rise_en_i = 0; fall_en_i = 0; irq_en_i = 0;
    func_raw_i = 0; out_inv_i = 0; pin_oe_i = 0; flag_clr_i = 0;
    repeat (4) step();
    rst_n = 1;
    repeat (4) step();
    t_reset();
    t_polarity();
    t_disabled();
    t_pin();
    t_rise();
    t_fall();
    t_ignored();
    t_wake();
    t_irq();
    t_clear();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule